// File: doc/BRIEF.md
# Cache-Block Zero Store Engine

This engine clears one aligned cache block in memory for each request it accepts. A request brings a byte address, which may point anywhere inside the block. The engine rounds that address down to the block boundary. It asks a permission port whether the whole block may be stored to. Only after a clean answer does it issue zero writes on a memory write port. When the answer marks the block as ordinary memory, the writes are full-width beats. When it marks the block as an uncached I/O region, every byte of the block is stored on its own, lowest address first. The zeros are written whether or not the locations are cacheable.

The request side is a valid/ready handshake and carries only one request at a time. A request is taken on a cycle with `req_valid` and `req_ready` both high. The probe request and the write port are valid/ready outputs: the engine holds each one steady until the other side takes it, so downstream back-pressure only adds cycles. The probe answer comes back as a one-cycle strobe. The result is a one-cycle `done` pulse, or a `fault` pulse that carries the probe's cause code.

Top module: `cbz_engine`

## Requirements
- R1: The block base is `req_addr` with its low log2(BLOCK_BYTES) bits cleared. An unaligned request address raises no error. The probe address and every write address are derived from this base.
- R2: `req_ready` is high only while idle. It goes low in the cycle after a request is accepted and comes back high in the cycle after the `done` or `fault` pulse. While the engine is busy, `req_valid` and `req_addr` have no effect.
- R3: Each request makes exactly one probe. The probe carries the block base on `probe_addr` and BLOCK_BYTES on `probe_len`. `probe_valid` stays high until `probe_ready`. No write is issued before a probe response that reports no fault.
- R4: A response with `probe_rsp_fault`=1 ends the request. It gives a one-cycle `fault` pulse with `fault_cause` equal to the `probe_rsp_cause` of that response. No write is issued, and the fault wins over `probe_rsp_io`.
- R5: For a response with no fault and `probe_rsp_io`=0, the engine issues BLOCK_BYTES/DATA_BYTES writes. The addresses run base, base+DATA_BYTES, and so on upward. Each write has `wr_byte`=0, `wr_strb` all ones and `wr_data` zero.
- R6: For a response with no fault and `probe_rsp_io`=1, the engine issues BLOCK_BYTES single-byte writes. The addresses run base, base+1, and so on upward. Each write has `wr_byte`=1, `wr_data` zero, and `wr_strb` one-hot with bit (`wr_addr` mod DATA_BYTES) set.
- R7: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr` and `wr_strb` hold their values. A write moves on only on a handshake.
- R8: `done` pulses for exactly one cycle, in the cycle after the handshake of the last write. `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Zero-block request valid |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | ADDR_W | Any byte address inside the target block |
| probe_valid | output | 1 | Store-permission probe request valid |
| probe_ready | input | 1 | Probe request taken |
| probe_addr | output | ADDR_W | Aligned block base being probed |
| probe_len | output | ADDR_W | Byte count covered by the probe (BLOCK_BYTES) |
| probe_rsp_valid | input | 1 | One-cycle probe answer strobe |
| probe_rsp_fault | input | 1 | Probe denied the store |
| probe_rsp_io | input | 1 | Block lies in an uncached I/O region |
| probe_rsp_cause | input | CAUSE_W | Fault cause code from the probe |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write taken |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 8*DATA_BYTES | Write data (always zero) |
| wr_strb | output | DATA_BYTES | Byte-lane enables |
| wr_byte | output | 1 | Single-byte store marker |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle abort pulse |
| fault_cause | output | CAUSE_W | Cause code, valid with `fault` |

## Verification
The bench sends unaligned addresses, including one that lies in the top block of the address space. A design that got the rounding wrong would probe or write the wrong bytes, or wrap past the top. Faulting probes are sent with the I/O flag both clear and set, to catch any write that leaks out before or after a denial, and any case where the flag is allowed to override the fault. Stalls on the probe and write ports in irregular patterns catch a beat that is skipped or repeated, or an address that changes while it waits. One request holds `req_valid` high with a different address for the whole time the engine is busy, which shows whether a busy engine takes a second request.

// File: rtl/cbz_pkg.sv
package cbz_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_WAIT,
    ST_WRITE,
    ST_DONE,
    ST_FAULT
  } cbz_state_e;
endpackage

// File: rtl/cbz_addr_align.sv
module cbz_addr_align #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_out
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BLOCK_BYTES - 1);

  // Clear the offset-within-block bits; misalignment is never an error.
  always_comb base_out = addr_in & ~LOW_MASK;
endmodule

// File: rtl/cbz_beat_seq.sv
module cbz_beat_seq #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int DATA_BYTES  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  advance,
  input  logic                  io_mode,
  input  logic [ADDR_W-1:0]     base,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_BYTES-1:0] beat_strb,
  output logic                  beat_last
);
  localparam int CNT_W  = $clog2(BLOCK_BYTES);
  localparam int BEATS  = BLOCK_BYTES / DATA_BYTES;
  localparam int LANE_W = $clog2(DATA_BYTES);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (advance) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (io_mode) offset = ADDR_W'(cnt_q);
    else         offset = ADDR_W'(cnt_q) << LANE_W;
    beat_addr = base + offset;
    beat_last = io_mode ? (cnt_q == CNT_W'(BLOCK_BYTES - 1))
                        : (cnt_q == CNT_W'(BEATS - 1));
  end

  generate
    if (DATA_BYTES > 1) begin : g_lanes
      logic [LANE_W-1:0] lane;
      always_comb begin
        lane      = beat_addr[LANE_W-1:0];
        beat_strb = io_mode ? (DATA_BYTES'(1) << lane) : '1;
      end
    end else begin : g_single
      always_comb beat_strb = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/cbz_ctrl.sv
module cbz_ctrl
  import cbz_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               probe_ready,
  input  logic               probe_rsp_valid,
  input  logic               probe_rsp_fault,
  input  logic               probe_rsp_io,
  input  logic [CAUSE_W-1:0] probe_rsp_cause,
  input  logic               wr_ready,
  input  logic               beat_last,
  output logic               req_ready,
  output logic               accept,
  output logic               probe_valid,
  output logic               wr_valid,
  output logic               advance,
  output logic               io_mode,
  output logic               done,
  output logic               fault,
  output logic [CAUSE_W-1:0] fault_cause
);
  cbz_state_e        state_q, state_d;
  logic              io_q;
  logic [CAUSE_W-1:0] cause_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid)   state_d = ST_PROBE;
      ST_PROBE: if (probe_ready) state_d = ST_WAIT;
      ST_WAIT:  if (probe_rsp_valid)
                  state_d = probe_rsp_fault ? ST_FAULT : ST_WRITE;
      ST_WRITE: if (wr_ready && beat_last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      io_q    <= 1'b0;
      cause_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT && probe_rsp_valid) begin
        io_q <= probe_rsp_io;
        if (probe_rsp_fault) cause_q <= probe_rsp_cause;
      end
    end
  end

  always_comb begin
    req_ready   = (state_q == ST_IDLE);
    accept      = req_ready && req_valid;
    probe_valid = (state_q == ST_PROBE);
    wr_valid    = (state_q == ST_WRITE);
    advance     = wr_valid && wr_ready;
    done        = (state_q == ST_DONE);
    fault       = (state_q == ST_FAULT);
    io_mode     = io_q;
    fault_cause = cause_q;
  end
endmodule

// File: rtl/cbz_engine.sv
module cbz_engine #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int DATA_BYTES  = 8,
  parameter int CAUSE_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    probe_valid,
  input  logic                    probe_ready,
  output logic [ADDR_W-1:0]       probe_addr,
  output logic [ADDR_W-1:0]       probe_len,
  input  logic                    probe_rsp_valid,
  input  logic                    probe_rsp_fault,
  input  logic                    probe_rsp_io,
  input  logic [CAUSE_W-1:0]      probe_rsp_cause,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [8*DATA_BYTES-1:0] wr_data,
  output logic [DATA_BYTES-1:0]   wr_strb,
  output logic                    wr_byte,
  output logic                    done,
  output logic                    fault,
  output logic [CAUSE_W-1:0]      fault_cause
);
  logic [ADDR_W-1:0] aligned, base_q;
  logic              accept, advance, io_mode, beat_last;

  cbz_addr_align #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_align (
    .addr_in (req_addr),
    .base_out(aligned)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (accept) base_q <= aligned;
  end

  cbz_ctrl #(.CAUSE_W(CAUSE_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .probe_ready    (probe_ready),
    .probe_rsp_valid(probe_rsp_valid),
    .probe_rsp_fault(probe_rsp_fault),
    .probe_rsp_io   (probe_rsp_io),
    .probe_rsp_cause(probe_rsp_cause),
    .wr_ready       (wr_ready),
    .beat_last      (beat_last),
    .req_ready      (req_ready),
    .accept         (accept),
    .probe_valid    (probe_valid),
    .wr_valid       (wr_valid),
    .advance        (advance),
    .io_mode        (io_mode),
    .done           (done),
    .fault          (fault),
    .fault_cause    (fault_cause)
  );

  cbz_beat_seq #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .DATA_BYTES(DATA_BYTES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .advance  (advance),
    .io_mode  (io_mode),
    .base     (base_q),
    .beat_addr(wr_addr),
    .beat_strb(wr_strb),
    .beat_last(beat_last)
  );

  always_comb begin
    probe_addr = base_q;
    probe_len  = ADDR_W'(BLOCK_BYTES);
    wr_data    = '0;
    wr_byte    = io_mode;
  end
endmodule

// File: rtl/cbz_engine_chk.sv
module cbz_engine_chk #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int DATA_BYTES  = 8,
  parameter int CAUSE_W     = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  probe_valid,
  input logic                  probe_ready,
  input logic [ADDR_W-1:0]     probe_addr,
  input logic                  probe_rsp_valid,
  input logic                  probe_rsp_fault,
  input logic [CAUSE_W-1:0]    probe_rsp_cause,
  input logic                  wr_valid,
  input logic                  wr_ready,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [DATA_BYTES-1:0] wr_strb,
  input logic                  wr_byte,
  input logic                  done,
  input logic                  fault,
  input logic [CAUSE_W-1:0]    fault_cause
);
  localparam logic [ADDR_W-1:0] BLK_LOW = ADDR_W'(BLOCK_BYTES - 1);
  localparam logic [ADDR_W-1:0] DB_A    = ADDR_W'(DATA_BYTES);

  assert_probe_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> ((probe_addr & BLK_LOW) == '0));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_probe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && !probe_ready) |=> (probe_valid && $stable(probe_addr)));

  assert_no_write_during_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> !wr_valid);

  assert_fault_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($past(probe_rsp_valid && probe_rsp_fault) &&
               fault_cause == $past(probe_rsp_cause)));

  assert_beat_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_byte) |-> ((wr_addr % DB_A) == '0 && (&wr_strb)));

  assert_byte_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_byte) |-> $onehot0(wr_strb) && (wr_strb != '0));

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_strb)));

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready));

  assert_done_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
endmodule

bind cbz_engine cbz_engine_chk #(
  .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .DATA_BYTES(DATA_BYTES), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .probe_valid(probe_valid), .probe_ready(probe_ready), .probe_addr(probe_addr),
  .probe_rsp_valid(probe_rsp_valid), .probe_rsp_fault(probe_rsp_fault),
  .probe_rsp_cause(probe_rsp_cause), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_byte(wr_byte), .done(done),
  .fault(fault), .fault_cause(fault_cause)
);

// File: tb/tb_cbz_engine.sv
module tb_cbz_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int BLK = 64;
  localparam int DB  = 8;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic probe_ready = 1'b0;
  logic probe_rsp_valid = 1'b0, probe_rsp_fault = 1'b0, probe_rsp_io = 1'b0;
  logic [CW-1:0] probe_rsp_cause = '0;
  logic wr_ready = 1'b0;
  logic req_ready, probe_valid, wr_valid, wr_byte, done, fault;
  logic [AW-1:0] probe_addr, probe_len, wr_addr;
  logic [8*DB-1:0] wr_data;
  logic [DB-1:0] wr_strb;
  logic [CW-1:0] fault_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbz_engine #(.ADDR_W(AW), .BLOCK_BYTES(BLK), .DATA_BYTES(DB), .CAUSE_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .probe_valid(probe_valid), .probe_ready(probe_ready),
    .probe_addr(probe_addr), .probe_len(probe_len), .probe_rsp_valid(probe_rsp_valid),
    .probe_rsp_fault(probe_rsp_fault), .probe_rsp_io(probe_rsp_io),
    .probe_rsp_cause(probe_rsp_cause), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb), .wr_byte(wr_byte),
    .done(done), .fault(fault), .fault_cause(fault_cause)
  );

  typedef struct packed { logic [AW-1:0] addr; logic [DB-1:0] strb; logic byte_st; } wr_item_t;
  typedef struct packed { logic is_fault; logic [CW-1:0] cause; } rsp_item_t;

  wr_item_t  exp_wr[$];
  rsp_item_t exp_rsp[$];
  int checks = 0, errors = 0;
  int cyc = 0;
  bit busy = 0;
  bit cfg_fault = 0, cfg_io = 0;
  logic [CW-1:0] cfg_cause = '0;
  int cfg_delay = 1;
  logic [AW-1:0] exp_base = '0;
  int probes_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Environment + scoreboard monitor: samples at negedge, drives at posedge+1.
  initial begin
    int  rsp_cnt = 0;
    bit  rsp_pend = 0;
    bit  nxt_rsp = 0;
    bit  stall_seen = 0;
    logic [AW-1:0] stall_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      nxt_rsp = 0;
      if (rst_n) begin
        if (stall_seen) begin
          chk(wr_valid && wr_addr == stall_addr, "R7", "write held under stall",
              64'(wr_addr), 64'(stall_addr));
          stall_seen = 0;
        end
        if (wr_valid && !wr_ready) begin
          stall_seen = 1;
          stall_addr = wr_addr;
        end
        if (probe_valid && probe_ready) begin
          probes_seen++;
          chk(probe_addr == exp_base, "R1", "probe address", 64'(probe_addr), 64'(exp_base));
          chk(probe_len == AW'(BLK), "R3", "probe length", 64'(probe_len), 64'(BLK));
          rsp_cnt = cfg_delay;
          rsp_pend = 1;
        end else if (rsp_pend) begin
          if (rsp_cnt == 0) begin
            nxt_rsp = 1;
            rsp_pend = 0;
          end else rsp_cnt--;
        end
        if (wr_valid && wr_ready) begin
          if (exp_wr.size() == 0) begin
            chk(0, "R3/R4", "unexpected write", 64'(wr_addr), 64'hx);
          end else begin
            wr_item_t e;
            e = exp_wr.pop_front();
            chk(wr_addr == e.addr, e.byte_st ? "R6" : "R5", "write address",
                64'(wr_addr), 64'(e.addr));
            chk(wr_strb == e.strb && wr_byte == e.byte_st && wr_data == '0,
                e.byte_st ? "R6" : "R5", "strobe/byte/data",
                {wr_data[31:0], 16'(wr_strb), 15'd0, wr_byte},
                {32'd0, 16'(e.strb), 15'd0, e.byte_st});
          end
        end
        if (busy) chk(!req_ready, "R2", "ready low while busy", 64'(req_ready), 64'd0);
        if (done || fault) begin
          if (exp_rsp.size() == 0) begin
            chk(0, "R8", "unexpected response", {62'd0, done, fault}, 64'd0);
          end else begin
            rsp_item_t r;
            r = exp_rsp[0];
            chk(!(done && fault), "R8", "done and fault together", {63'd0, done}, 64'd0);
            if (r.is_fault) begin
              chk(fault && fault_cause == r.cause, "R4", "fault pulse/cause",
                  {59'd0, fault, fault_cause}, {59'd1, r.cause});
              chk(exp_wr.size() == 0, "R4", "writes on fault", 64'(exp_wr.size()), 64'd0);
            end else begin
              chk(done, "R8", "done pulse", 64'(done), 64'd1);
              chk(exp_wr.size() == 0, "R8", "writes left at done", 64'(exp_wr.size()), 64'd0);
            end
            busy = 0;
            void'(exp_rsp.pop_front());
          end
        end
      end
      @(posedge clk);
      #1;
      probe_ready     = (cyc % 3) != 0;
      wr_ready        = (cyc % 4) != 1 && (cyc % 7) != 3;
      probe_rsp_valid = nxt_rsp;
      probe_rsp_fault = nxt_rsp ? cfg_fault : 1'b0;
      probe_rsp_io    = nxt_rsp ? cfg_io : ~cfg_io;
      probe_rsp_cause = nxt_rsp ? cfg_cause : ~cfg_cause;
    end
  end

  // Driver: pushes expectations into the scoreboard queues, then issues the request.
  task automatic run_req(input logic [AW-1:0] addr, input bit f, input bit io,
                         input logic [CW-1:0] cause, input int delay, input bit hold);
    logic [AW-1:0] base;
    int p0;
    base = addr & ~AW'(BLK - 1);
    exp_base = base;
    cfg_fault = f; cfg_io = io; cfg_cause = cause; cfg_delay = delay;
    if (!f) begin
      if (io) begin
        for (int i = 0; i < BLK; i++) begin
          logic [AW-1:0] a;
          a = base + AW'(i);
          exp_wr.push_back('{addr: a, strb: DB'(1) << a[2:0], byte_st: 1'b1});
        end
      end else begin
        for (int i = 0; i < BLK/DB; i++)
          exp_wr.push_back('{addr: base + AW'(i*DB), strb: '1, byte_st: 1'b0});
      end
    end
    exp_rsp.push_back('{is_fault: f, cause: cause});
    p0 = probes_seen;
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = addr;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    busy = 1;
    if (hold) req_addr = ~addr;
    else req_valid = 1'b0;
    wait (exp_rsp.size() == 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready, "R2", "ready back after response", 64'(req_ready), 64'd1);
    chk(probes_seen == p0 + 1, "R3", "one probe per request", 64'(probes_seen - p0), 64'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !probe_valid && !wr_valid && !done && !fault, "R2", "reset state",
        {59'd0, req_ready, probe_valid, wr_valid, done, fault}, 64'h10);
    run_req(32'h1000_0013, 0, 0, 4'h0, 1, 0); // R1 R5 unaligned, normal memory
    run_req(32'h2000_0040, 0, 1, 4'h0, 2, 0); // R6 aligned, I/O bytes
    run_req(32'h3000_0077, 1, 0, 4'h5, 1, 0); // R4 fault, no writes
    run_req(32'h4000_00FF, 1, 1, 4'hA, 3, 0); // R4 fault beats I/O flag
    run_req(32'hFFFF_FFFF, 0, 0, 4'h0, 0, 0); // R1 top of address space
    run_req(32'h5000_0105, 0, 0, 4'h0, 2, 1); // R2 valid held while busy
    run_req(32'h6000_003F, 0, 1, 4'h0, 1, 1); // R6 R7 I/O with held valid
    repeat (5) @(negedge clk);
    chk(exp_wr.size() == 0 && !wr_valid, "R2", "no extra work after idle",
        64'(exp_wr.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule